// File: doc/BRIEF.md
# Double-to-Single Precision Converter

This block narrows a 64-bit binary floating-point operand to the 32-bit format in one clocked stage. The 52-bit source fraction is cut to 30 bits. Every discarded bit folds into a sticky bit. The hidden one is inserted, and the exponent is moved to the narrow bias with a single fixed subtraction. That subtraction also absorbs the one-position offset that the packing adder later adds back. A shared single-precision round-and-pack stage then produces the final word and the overflow, underflow and inexact flags.

The block has two rounding modes, nearest-even and truncation toward zero. Results that are too large saturate to infinity or to the largest finite magnitude, depending on the mode. Results that are too small are denormalised through the rounder. Source operands with an all-ones exponent get no special handling: they follow the same path as any other value whose exponent is out of range. Callers present an operand with a valid strobe and read the result one cycle later.

Top module: `d2s_convert`

## Requirements
- R1: An operand accepted with `in_valid` high appears on the outputs after the next rising clock edge, with `out_valid` high. In a cycle where `in_valid` is low, `out_valid` goes low after the edge, and the result and flag outputs keep their previous values.
- R2: Bit 31 of the result always equals bit 63 of the accepted operand.
- R3: A source value that is exactly representable as a normal single converts to that single with no flag raised.
- R4: `in_rnd_zero` = 0 selects round-to-nearest with ties going to the even significand. `in_rnd_zero` = 1 selects truncation toward zero.
- R5: All 22 low source fraction bits take part in rounding. If any of them is nonzero, a halfway case in nearest mode rounds upward and inexact is raised.
- R6: If the rounded magnitude exceeds the largest finite single, `out_ovf` and `out_inx` are both set. In mode 0 the result is infinity: exponent field all ones, fraction zero. In mode 1 the result is 0x7F7FFFFF with the operand's sign.
- R7: Values below the normal range become subnormals or zero. `out_unf` is set only when the value is tiny and the result is inexact. Tiny means the value would stay below 2^-126 if rounded in the selected mode with an unbounded exponent. An exact subnormal raises no flag.
- R8: +0 and -0 convert to a zero of the same sign with no flag raised.
- R9: `out_inx` is set exactly when the result differs from the source value.
- R10: An operand whose exponent field is all ones (infinity or NaN) is treated as an out-of-range magnitude and gives the R6 result and flags.
- R11: With `rst_n` low at a rising edge, `out_valid`, the result and all flags are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_dbl | input | 64 | 64-bit floating-point operand |
| in_rnd_zero | input | 1 | Rounding mode: 0 nearest-even, 1 toward zero |
| out_valid | output | 1 | Result valid, one cycle after the operand |
| out_sgl | output | 32 | 32-bit floating-point result |
| out_ovf | output | 1 | Overflow flag |
| out_unf | output | 1 | Underflow flag |
| out_inx | output | 1 | Inexact flag |

## Verification
The bench aims at exact halfway ties under both modes, including one case where only the lowest source fraction bit breaks the tie. A design that dropped the sticky reduction would round that case down and return the wrong last bit. The largest-finite boundary is tested just below and exactly at the rounding carry. A rebias off by one, or an overflow test made before rounding, would give infinity for the maximum value or miss the carry into infinity. On the small side, the bench covers the smallest subnormal, half of it, and a value one step below the normal range that rounds back up to 2^-126 in nearest mode but not toward zero. A tininess test made after the shift, or an underflow flag that ignores exactness, shows up there as a wrong `out_unf`. Source subnormals, source infinity and large exponents probe whether the rebiased exponent is kept wide and signed enough not to wrap.

// File: rtl/d2s_pkg.sv
// Package: format constants and shared types for the double-to-single
// converter. Assumes the standard binary64 and binary32 field layouts.
package d2s_pkg;
    localparam int SRC_EXP_W  = 11;
    localparam int SRC_FRAC_W = 52;
    localparam int DST_EXP_W  = 8;
    localparam int DST_FRAC_W = 23;
    localparam int GRD_W      = 7;                          // bits below the kept fraction

    localparam int SRC_W      = 1 + SRC_EXP_W + SRC_FRAC_W;
    localparam int DST_W      = 1 + DST_EXP_W + DST_FRAC_W;
    localparam int HID_POS    = DST_FRAC_W + GRD_W;         // hidden one position
    localparam int SIG_W      = HID_POS + 2;                // plus hidden bit and carry headroom
    localparam int RED_W      = HID_POS;                    // kept source fraction bits
    localparam int DROP_W     = SRC_FRAC_W - RED_W;         // folded into sticky
    localparam int SRC_BIAS   = (1 << (SRC_EXP_W - 1)) - 1;
    localparam int DST_BIAS   = (1 << (DST_EXP_W - 1)) - 1;
    localparam int REBIAS     = SRC_BIAS - DST_BIAS + 1;    // +1: packing adder re-adds the hidden one
    localparam int EXP_W      = SRC_EXP_W + 2;              // signed, room for both extremes
    localparam int OVF_EDGE   = (1 << DST_EXP_W) - 3;       // last exponent that may still fit

    typedef enum logic {
        RND_NEAR_EVEN = 1'b0,
        RND_TO_ZERO   = 1'b1
    } rnd_mode_e;

    typedef struct packed {
        logic                     sign;
        logic signed [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]         sig;
    } unrounded_t;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic inx;
    } flags_t;
endpackage

// File: rtl/d2s_narrow.sv
// Module: d2s_narrow
// Splits a 64-bit operand, reduces its fraction to RED_W bits with a sticky
// OR of the dropped bits, inserts the hidden one and rebiases the exponent.
// Assumes the caller rounds the result; zero is detected after reduction.
module d2s_narrow
    import d2s_pkg::*;
(
    input  logic [SRC_W-1:0] src,
    output unrounded_t       unr
);
    logic [SRC_EXP_W-1:0]  e_raw;
    logic [SRC_FRAC_W-1:0] frac;
    logic                  sticky;
    logic [RED_W-1:0]      red;
    logic                  nonzero;

    assign e_raw = src[SRC_W-2 -: SRC_EXP_W];
    assign frac  = src[SRC_FRAC_W-1:0];

    // Sticky bit exists only when the source fraction is wider than kept.
    generate
        if (DROP_W > 0) begin : g_sticky
            assign sticky = |frac[DROP_W-1:0];
        end else begin : g_no_sticky
            assign sticky = 1'b0;
        end
    endgenerate

    assign red     = frac[SRC_FRAC_W-1 -: RED_W] | {{(RED_W-1){1'b0}}, sticky};
    assign nonzero = (e_raw != '0) || (red != '0);

    // Build the unrounded value: hidden one and rebias unless the value is zero.
    always_comb begin
        unr.sign = src[SRC_W-1];
        unr.exp  = '0;
        unr.sig  = '0;
        if (nonzero) begin
            unr.exp = $signed({2'b00, e_raw}) - $signed(EXP_W'(REBIAS));
            unr.sig = {1'b0, 1'b1, red};
        end
    end
endmodule

// File: rtl/d2s_round_pack.sv
// Module: d2s_round_pack
// Single-precision round-and-pack. Takes a sign, a signed exponent one below
// the biased target, and a significand with the hidden one at HID_POS.
// Saturates on overflow, denormalises with a sticky shift on underflow, and
// rounds nearest-even or toward zero. Assumes sig[SIG_W-1] is clear on entry.
module d2s_round_pack
    import d2s_pkg::*;
(
    input  unrounded_t       unr,
    input  rnd_mode_e        mode,
    output logic [DST_W-1:0] result,
    output flags_t           flags
);
    localparam int                      MANT_W = SIG_W - GRD_W;
    localparam logic [SIG_W-1:0]        HALF   = SIG_W'(1) << (GRD_W - 1);
    localparam logic signed [EXP_W-1:0] EDGE   = EXP_W'(OVF_EDGE);
    localparam logic [EXP_W-1:0]        MINUS1 = {EXP_W{1'b1}};

    // Right shift that ORs every bit shifted out into bit 0.
    function automatic logic [SIG_W-1:0] jam_right(input logic [SIG_W-1:0] v,
                                                   input logic [EXP_W-1:0] n);
        logic [SIG_W-1:0] mask;
        if (n >= EXP_W'(SIG_W)) begin
            jam_right = SIG_W'(|v);
        end else begin
            mask      = ~({SIG_W{1'b1}} << n);
            jam_right = (v >> n) | SIG_W'(|(v & mask));
        end
    endfunction

    logic                    near;
    logic [SIG_W-1:0]        inc;
    logic [SIG_W-1:0]        pre_sum;
    logic signed [EXP_W-1:0] exp_in;
    logic                    too_big;
    logic                    tiny;
    logic [EXP_W-1:0]        shamt;
    logic [SIG_W-1:0]        den_sig;
    logic signed [EXP_W-1:0] exp_adj;
    logic [GRD_W-1:0]        rbits;
    logic [SIG_W-1:0]        rnd_sum;
    logic [MANT_W-1:0]       mant;
    logic [DST_EXP_W-1:0]    exp_keep;

    // Mode decode and the overflow decision, made with the rounding carry.
    always_comb begin
        near    = (mode == RND_NEAR_EVEN);
        inc     = near ? HALF : '0;
        exp_in  = unr.exp;
        pre_sum = unr.sig + inc;
        too_big = (exp_in > EDGE) || ((exp_in == EDGE) && pre_sum[SIG_W-1]);
    end

    // Denormalise negative exponents; tininess judged before the shift.
    always_comb begin
        tiny    = 1'b0;
        shamt   = '0;
        den_sig = unr.sig;
        exp_adj = exp_in;
        if (exp_in[EXP_W-1]) begin
            tiny    = (exp_in != MINUS1) || !pre_sum[SIG_W-1];
            shamt   = -exp_in;
            den_sig = jam_right(unr.sig, shamt);
            exp_adj = '0;
        end
    end

    // Round, clear the last bit on an exact tie, pack and raise flags.
    always_comb begin
        rbits   = den_sig[GRD_W-1:0];
        rnd_sum = den_sig + inc;
        mant    = rnd_sum[SIG_W-1:GRD_W];
        if (near && (rbits == HALF[GRD_W-1:0])) begin
            mant[0] = 1'b0;
        end
        exp_keep = (mant == '0) ? '0 : exp_adj[DST_EXP_W-1:0];
        flags    = '0;
        if (too_big) begin
            flags.ovf = 1'b1;
            flags.inx = 1'b1;
            result = near ? {unr.sign, {DST_EXP_W{1'b1}}, {DST_FRAC_W{1'b0}}}
                          : {unr.sign, {(DST_EXP_W-1){1'b1}}, 1'b0, {DST_FRAC_W{1'b1}}};
        end else begin
            flags.inx = |rbits;
            flags.unf = tiny && (|rbits);
            result = {unr.sign, {(DST_W-1){1'b0}}}
                   + {1'b0, exp_keep, {DST_FRAC_W{1'b0}}}
                   + DST_W'(mant);
        end
    end
endmodule

// File: rtl/d2s_convert.sv
// Module: d2s_convert (top)
// Registered double-to-single converter: narrow stage, shared rounder, one
// output register. Synchronous active-low reset. Outputs hold while idle.
module d2s_convert
    import d2s_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] in_dbl,
    input  logic             in_rnd_zero,
    output logic             out_valid,
    output logic [DST_W-1:0] out_sgl,
    output logic             out_ovf,
    output logic             out_unf,
    output logic             out_inx
);
    unrounded_t       unr;
    logic [DST_W-1:0] rnd_res;
    flags_t           rnd_flg;
    rnd_mode_e        mode;

    assign mode = rnd_mode_e'(in_rnd_zero);

    d2s_narrow u_narrow (
        .src (in_dbl),
        .unr (unr)
    );

    d2s_round_pack u_round (
        .unr    (unr),
        .mode   (mode),
        .result (rnd_res),
        .flags  (rnd_flg)
    );

    // Output register: capture on valid, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sgl   <= '0;
            out_ovf   <= 1'b0;
            out_unf   <= 1'b0;
            out_inx   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sgl <= rnd_res;
                out_ovf <= rnd_flg.ovf;
                out_unf <= rnd_flg.unf;
                out_inx <= rnd_flg.inx;
            end
        end
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_sgl) && $stable(out_inx)));
    p_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_sgl[DST_W-1] == $past(in_dbl[SRC_W-1])));
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ovf) |-> (out_inx &&
            ((out_sgl[DST_W-2:0] == 31'h7F800000) || (out_sgl[DST_W-2:0] == 31'h7F7FFFFF))));
    p_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_unf) |-> (out_inx && !out_ovf && (out_sgl[DST_W-2:DST_FRAC_W+1] == '0)));
    p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_dbl[SRC_W-2:0] == '0)) |=>
            ((out_sgl[DST_W-2:0] == '0) && !out_ovf && !out_unf && !out_inx));
    p_all_ones_exp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_dbl[SRC_W-2 -: SRC_EXP_W] == '1)) |=> out_ovf);
endmodule

// File: tb/d2s_convert_test.sv
// Bench for d2s_convert: a vector table walked by one loop, then directed
// checks for idle hold and reset.
module d2s_convert_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_dbl = '0;
    logic        in_rnd_zero = 1'b0;
    logic        out_valid;
    logic [31:0] out_sgl;
    logic        out_ovf, out_unf, out_inx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    d2s_convert uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_dbl      (in_dbl),
        .in_rnd_zero (in_rnd_zero),
        .out_valid   (out_valid),
        .out_sgl     (out_sgl),
        .out_ovf     (out_ovf),
        .out_unf     (out_unf),
        .out_inx     (out_inx)
    );

    // Row: operand, mode (1 = toward zero), expected result, {ovf,unf,inx}, requirement.
    localparam int NV = 26;
    localparam logic [107:0] VEC [NV] = '{
        {64'h3FF0000000000000, 1'b0, 32'h3F800000, 3'b000, 8'd3},  // R3 exact 1.0
        {64'hC004000000000000, 1'b0, 32'hC0200000, 3'b000, 8'd2},  // R2 negative, exact
        {64'h0000000000000000, 1'b0, 32'h00000000, 3'b000, 8'd8},  // R8 +0
        {64'h8000000000000000, 1'b1, 32'h80000000, 3'b000, 8'd8},  // R8 -0
        {64'h3FF0000010000000, 1'b0, 32'h3F800000, 3'b001, 8'd4},  // R4 tie to even (down)
        {64'h3FF0000010000000, 1'b1, 32'h3F800000, 3'b001, 8'd4},  // R4 truncate
        {64'h3FF0000030000000, 1'b0, 32'h3F800002, 3'b001, 8'd4},  // R4 tie to even (up)
        {64'h3FF0000030000000, 1'b1, 32'h3F800001, 3'b001, 8'd4},  // R4 truncate odd
        {64'h3FF0000010000001, 1'b0, 32'h3F800001, 3'b001, 8'd5},  // R5 sticky breaks tie
        {64'h3FF0000010000001, 1'b1, 32'h3F800000, 3'b001, 8'd5},  // R5 truncate with sticky
        {64'h47EFFFFFE0000000, 1'b0, 32'h7F7FFFFF, 3'b000, 8'd3},  // R3 largest finite
        {64'h47EFFFFFF0000000, 1'b0, 32'h7F800000, 3'b101, 8'd6},  // R6 carry into infinity
        {64'h47EFFFFFF0000000, 1'b1, 32'h7F7FFFFF, 3'b001, 8'd6},  // R6 no carry toward zero
        {64'h7FE0000000000000, 1'b0, 32'h7F800000, 3'b101, 8'd6},  // R6 huge, nearest
        {64'hFFE0000000000000, 1'b1, 32'hFF7FFFFF, 3'b101, 8'd6},  // R6 huge negative, toward zero
        {64'h7FF0000000000000, 1'b0, 32'h7F800000, 3'b101, 8'd10}, // R10 infinity operand
        {64'h36A0000000000000, 1'b0, 32'h00000001, 3'b000, 8'd7},  // R7 exact min subnormal
        {64'h3690000000000000, 1'b0, 32'h00000000, 3'b011, 8'd7},  // R7 half min subnormal tie
        {64'h3698000000000000, 1'b0, 32'h00000001, 3'b011, 8'd7},  // R7 rounds up to min subnormal
        {64'h3698000000000000, 1'b1, 32'h00000000, 3'b011, 8'd7},  // R7 truncates to zero
        {64'h3810000000000000, 1'b0, 32'h00800000, 3'b000, 8'd3},  // R3 min normal
        {64'h380FFFFFFFFFFFFF, 1'b0, 32'h00800000, 3'b001, 8'd7},  // R7 not tiny, rounds to normal
        {64'h380FFFFFFFFFFFFF, 1'b1, 32'h007FFFFF, 3'b011, 8'd7},  // R7 tiny toward zero
        {64'h8000000000000001, 1'b0, 32'h80000000, 3'b011, 8'd7},  // R7 source subnormal
        {64'h3FB999999999999A, 1'b0, 32'h3DCCCCCD, 3'b001, 8'd9},  // R9 0.1 nearest
        {64'h3FB999999999999A, 1'b1, 32'h3DCCCCCC, 3'b001, 8'd9}   // R9 0.1 toward zero
    };

    task automatic chk(input string what, input int req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("reset valid", 11, 64'(out_valid), 64'd0);
        chk("reset result", 11, 64'(out_sgl), 64'd0);
        chk("reset flags", 11, 64'({out_ovf, out_unf, out_inx}), 64'd0);
        rst_n = 1'b1;

        // Table walk; operands stream back to back, each checked one edge later.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            in_valid    = 1'b1;
            in_dbl      = VEC[i][107:44];
            in_rnd_zero = VEC[i][43];
            @(negedge clk);
            chk($sformatf("vec %0d valid", i), 1, 64'(out_valid), 64'd1);
            chk($sformatf("vec %0d result", i), int'(VEC[i][7:0]), 64'(out_sgl), 64'(VEC[i][42:11]));
            chk($sformatf("vec %0d flags", i), int'(VEC[i][7:0]), 64'({out_ovf, out_unf, out_inx}),
                64'(VEC[i][10:8]));
            chk($sformatf("vec %0d sign", i), 2, 64'(out_sgl[31]), 64'(VEC[i][107]));
        end

        // R1: idle cycle keeps the last result and drops valid
        @(negedge clk);
        in_valid = 1'b0;
        in_dbl   = 64'h7FF0000000000000;
        @(negedge clk);
        chk("idle valid", 1, 64'(out_valid), 64'd0);
        chk("idle result held", 1, 64'(out_sgl), 64'h3DCCCCCC);
        chk("idle flags held", 1, 64'({out_ovf, out_unf, out_inx}), 64'd1);

        // R10: NaN operand saturates like an out-of-range value
        in_valid    = 1'b1;
        in_dbl      = 64'hFFF8000000000000;
        in_rnd_zero = 1'b1;
        @(negedge clk);
        chk("nan toward zero", 10, 64'(out_sgl), 64'hFF7FFFFF);
        chk("nan flags", 10, 64'({out_ovf, out_unf, out_inx}), 64'd5);

        // R11: reset in mid-stream clears everything
        rst_n = 1'b0;
        @(negedge clk);
        chk("mid reset valid", 11, 64'(out_valid), 64'd0);
        chk("mid reset result", 11, 64'(out_sgl), 64'd0);
        chk("mid reset flags", 11, 64'({out_ovf, out_unf, out_inx}), 64'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule